// File: doc/BRIEF.md
# Free-Running Cycle Count Timer

This block holds the 32-bit cycle count register of a processor control coprocessor. While counting is enabled it advances by one on every second clock edge. It does not depend on whether instructions issue, retire or stall. Software can load a new count at any time. A disable bit stops the count. A debug-mode input, qualified by a keep-running bit, can also freeze it. A companion compare register raises a hit flag on the same edge that an increment brings the count equal to it. The flag stays set until software writes the compare register again.

The every-other-clock pacing comes from a small phase machine with three states:

- `PH_WAIT` is the half-period with no increment.
- `PH_STEP` is the half-period that ends in an increment.
- `PH_HOLD` means counting is gated off.

The transitions are as follows:

- **WAIT→STEP** on an edge while running.
- **STEP→WAIT** on an edge while running, and the count increments on that edge.
- **WAIT→HOLD** and **STEP→HOLD** when gating turns on.
- **HOLD→WAIT** when gating turns off.
- **HOLD→HOLD** while gating stays on.
- **any→WAIT** on a count load while running, or **any→HOLD** on a count load while gated. A load always wins over the current state.

Top module: `cyc_timer`

## Requirements
- R1: While running, `cnt_value` increases by exactly one on every second rising edge and never on two consecutive edges; running means `cnt_halt`=0 and not (`dbg_active`=1 and `dbg_keep_run`=0).
- R2: While `cnt_halt`=1, `cnt_value` holds its value, whatever the debug inputs are.
- R3: While `dbg_active`=1 and `dbg_keep_run`=0, `cnt_value` holds; with `dbg_keep_run`=1 it keeps counting in debug mode.
- R4: A rising edge with `cnt_wr_en`=1 loads `cnt_wr_data` into `cnt_value`, zero included; if that edge would also have incremented, the loaded value is kept unchanged.
- R5: A load restarts the phase: with counting enabled, the first increment after a load lands on the second rising edge after the load edge.
- R6: When gating is released from the hold state, the first increment lands on the third rising edge that samples counting enabled.
- R7: The count wraps from 0xFFFFFFFF to 0x00000000, and no flag records the wrap.
- R8: A rising edge with `cmp_wr_en`=1 loads `cmp_wr_data` into `cmp_value`; `cmp_hit` becomes 1 on the edge where an increment makes `cnt_value` equal to `cmp_value`, and stays 1 afterwards.
- R9: A compare load clears `cmp_hit` on its edge, and this clear wins over a hit landing on the same edge.
- R10: After reset, `cnt_value`=0, `cmp_value`=0, `cmp_hit`=0, and the phase is `PH_WAIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_wr_en | input | 1 | Load strobe for the count |
| cnt_wr_data | input | 32 | Value to load into the count |
| cmp_wr_en | input | 1 | Load strobe for the compare register |
| cmp_wr_data | input | 32 | Value to load into the compare register |
| cnt_halt | input | 1 | Disable bit; 1 stops counting |
| dbg_active | input | 1 | Processor is in debug mode |
| dbg_keep_run | input | 1 | 1 lets the count run in debug mode |
| cnt_value | output | 32 | Current count |
| cmp_value | output | 32 | Current compare value |
| cmp_hit | output | 1 | Pending compare match |

## Verification
The hardest cases to reach are the coincidences: a count load arriving on the very edge that would have incremented, and a compare load arriving on the edge where an increment reaches the compare value. Neither phase nor pending state is visible at the ports. The stimulus therefore starts every scenario with a count load, which puts the phase in a known state. It then counts edges from that load so that the second strobe falls exactly on a `PH_STEP` edge. After each coincidence the bench checks the edges that follow, which shows that the phase restarted or that the flag stayed cleared.

// File: rtl/cyc_timer_pkg.sv
`timescale 1ns/1ps
package cyc_timer_pkg;
    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_STEP = 2'd1,
        PH_HOLD = 2'd2
    } ph_state_t;
endpackage

// File: rtl/cyc_phase_fsm.sv
`timescale 1ns/1ps
module cyc_phase_fsm
    import cyc_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic load,
    output logic step
);
    ph_state_t st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PH_WAIT;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (load) begin
            st_nxt = run ? PH_WAIT : PH_HOLD;
        end else begin
            unique case (st)
                PH_WAIT: st_nxt = run ? PH_STEP : PH_HOLD;
                PH_STEP: st_nxt = run ? PH_WAIT : PH_HOLD;
                PH_HOLD: st_nxt = run ? PH_WAIT : PH_HOLD;
                default: st_nxt = PH_WAIT;
            endcase
        end
    end

    always_comb begin
        step = (st == PH_STEP) && run && !load;
    end

    // R1
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

    // R2
    gate_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !step);

    // R5
    load_restarts_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !step);
endmodule

// File: rtl/cyc_count_reg.sv
`timescale 1ns/1ps
module cyc_count_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             step,
    output logic [WIDTH-1:0] cnt,
    output logic [WIDTH-1:0] cnt_inc
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb cnt_inc = cnt + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (step)  cnt <= cnt_inc;
    end

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R1
    step_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cnt == $past(cnt) + ONE);

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt));
endmodule

// File: rtl/cyc_cmp_unit.sv
`timescale 1ns/1ps
module cyc_cmp_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wr_val,
    input  logic             step,
    input  logic             cnt_load,
    input  logic [WIDTH-1:0] cnt_inc,
    input  logic [WIDTH-1:0] cnt,
    output logic [WIDTH-1:0] cmp,
    output logic             hit
);
    logic lands;

    always_comb lands = step && !cnt_load && (cnt_inc == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cmp <= '0;
        else if (wr) cmp <= wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hit <= 1'b0;
        else if (wr)    hit <= 1'b0;
        else if (lands) hit <= 1'b1;
    end

    // R8
    hit_on_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> cnt == cmp);

    // R9
    cmp_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !hit);

    // R8
    hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr) |=> hit);
endmodule

// File: rtl/cyc_timer.sv
`timescale 1ns/1ps
module cyc_timer #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_en,
    input  logic [WIDTH-1:0] cnt_wr_data,
    input  logic             cmp_wr_en,
    input  logic [WIDTH-1:0] cmp_wr_data,
    input  logic             cnt_halt,
    input  logic             dbg_active,
    input  logic             dbg_keep_run,
    output logic [WIDTH-1:0] cnt_value,
    output logic [WIDTH-1:0] cmp_value,
    output logic             cmp_hit
);
    logic run;
    logic step;
    logic [WIDTH-1:0] cnt_inc;

    always_comb run = !cnt_halt && (!dbg_active || dbg_keep_run);

    cyc_phase_fsm u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .load (cnt_wr_en),
        .step (step)
    );

    cyc_count_reg #(.WIDTH(WIDTH)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_wr_en),
        .load_val(cnt_wr_data),
        .step    (step),
        .cnt     (cnt_value),
        .cnt_inc (cnt_inc)
    );

    cyc_cmp_unit #(.WIDTH(WIDTH)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cmp_wr_en),
        .wr_val  (cmp_wr_data),
        .step    (step),
        .cnt_load(cnt_wr_en),
        .cnt_inc (cnt_inc),
        .cnt     (cnt_value),
        .cmp     (cmp_value),
        .hit     (cmp_hit)
    );

    // R3
    dbg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_active && !dbg_keep_run && !cnt_wr_en) |=> $stable(cnt_value));

    // R2
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_halt && !cnt_wr_en) |=> $stable(cnt_value));
endmodule

// File: tb/sim_cyc_timer.sv
`timescale 1ns/1ps
module sim_cyc_timer;
    localparam int W  = 32;
    localparam int VW = 75;
    localparam int NV = 10;

    // {halt, dbg, keep, edges[7:0], load data, expected count}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'd1,  32'h0000_0010, 32'h0000_0010},
        {1'b0, 1'b0, 1'b0, 8'd2,  32'h0000_0010, 32'h0000_0010},
        {1'b0, 1'b0, 1'b0, 8'd3,  32'h0000_0010, 32'h0000_0011},
        {1'b0, 1'b0, 1'b0, 8'd9,  32'h0000_0010, 32'h0000_0014},
        {1'b0, 1'b0, 1'b0, 8'd3,  32'hFFFF_FFFF, 32'h0000_0000},
        {1'b1, 1'b0, 1'b0, 8'd10, 32'h0000_0100, 32'h0000_0100},
        {1'b0, 1'b1, 1'b0, 8'd10, 32'h0000_0200, 32'h0000_0200},
        {1'b0, 1'b1, 1'b1, 8'd7,  32'h0000_0300, 32'h0000_0303},
        {1'b0, 1'b0, 1'b0, 8'd5,  32'h0000_0000, 32'h0000_0002},
        {1'b1, 1'b1, 1'b1, 8'd6,  32'h0000_0055, 32'h0000_0055}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_wr_en = 1'b0;
    logic [W-1:0] cnt_wr_data = '0;
    logic cmp_wr_en = 1'b0;
    logic [W-1:0] cmp_wr_data = '0;
    logic cnt_halt = 1'b0;
    logic dbg_active = 1'b0;
    logic dbg_keep_run = 1'b0;
    logic [W-1:0] cnt_value;
    logic [W-1:0] cmp_value;
    logic cmp_hit;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    cyc_timer #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .cnt_halt(cnt_halt), .dbg_active(dbg_active), .dbg_keep_run(dbg_keep_run),
        .cnt_value(cnt_value), .cmp_value(cmp_value), .cmp_hit(cmp_hit)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string vtag(input int i);
        case (i)
            0, 8:    return "R4";
            1:       return "R5";
            2, 3:    return "R1";
            4:       return "R7";
            5, 9:    return "R2";
            default: return "R3";
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        edges(3);
        // R10 reset state
        chk("R10 count", cnt_value, '0);
        chk("R10 compare", cmp_value, '0);
        chk("R10 hit", {31'b0, cmp_hit}, '0);
        rst_n = 1'b1;
        // R10: phase starts in PH_WAIT, so first increment is on the second edge
        edges(1);
        chk("R10 phase", cnt_value, 32'h0);
        edges(1);
        chk("R10 phase", cnt_value, 32'h1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            cnt_halt     = VEC[i][74];
            dbg_active   = VEC[i][73];
            dbg_keep_run = VEC[i][72];
            cnt_wr_data  = VEC[i][63:32];
            cnt_wr_en    = 1'b1;
            edges(1);
            cnt_wr_en = 1'b0;
            edges(int'(VEC[i][71:64]) - 1);
            chk(vtag(i), cnt_value, VEC[i][31:0]);
        end
        cnt_halt = 1'b0; dbg_active = 1'b0; dbg_keep_run = 1'b0;

        // R4: load coinciding with an increment edge wins, R5 phase restarts
        cnt_wr_data = 32'h1000; cnt_wr_en = 1'b1;
        edges(1);
        cnt_wr_en = 1'b0;
        edges(1);
        cnt_wr_data = 32'h2000; cnt_wr_en = 1'b1;
        edges(1);
        cnt_wr_en = 1'b0;
        chk("R4 coincide", cnt_value, 32'h2000);
        edges(1);
        chk("R5 restart", cnt_value, 32'h2000);
        edges(1);
        chk("R5 restart", cnt_value, 32'h2001);

        // R6: release from hold
        cnt_halt = 1'b1; cnt_wr_data = 32'h700; cnt_wr_en = 1'b1;
        edges(1);
        cnt_wr_en = 1'b0;
        edges(2);
        cnt_halt = 1'b0;
        edges(2);
        chk("R6 resume", cnt_value, 32'h700);
        edges(1);
        chk("R6 resume", cnt_value, 32'h701);

        // R3: debug freeze mid-count
        cnt_wr_data = 32'h800; cnt_wr_en = 1'b1;
        edges(1);
        cnt_wr_en = 1'b0;
        edges(2);
        chk("R3 pre", cnt_value, 32'h801);
        dbg_active = 1'b1;
        edges(6);
        chk("R3 freeze", cnt_value, 32'h801);
        dbg_active = 1'b0;

        // R8: compare hit
        cmp_wr_data = 32'h505; cmp_wr_en = 1'b1;
        cnt_wr_data = 32'h503; cnt_wr_en = 1'b1;
        edges(1);
        cmp_wr_en = 1'b0; cnt_wr_en = 1'b0;
        chk("R8 cmp load", cmp_value, 32'h505);
        edges(3);
        chk("R8 no hit yet", {31'b0, cmp_hit}, 32'h0);
        chk("R8 count", cnt_value, 32'h504);
        edges(1);
        chk("R8 hit", {31'b0, cmp_hit}, 32'h1);
        chk("R8 count", cnt_value, 32'h505);
        edges(2);
        chk("R8 sticky", {31'b0, cmp_hit}, 32'h1);
        cmp_wr_data = 32'h600; cmp_wr_en = 1'b1;
        edges(1);
        cmp_wr_en = 1'b0;
        chk("R9 clear", {31'b0, cmp_hit}, 32'h0);
        chk("R8 cmp load", cmp_value, 32'h600);

        // R9: clear wins over coincident hit
        cmp_wr_data = 32'h901; cmp_wr_en = 1'b1;
        cnt_wr_data = 32'h900; cnt_wr_en = 1'b1;
        edges(1);
        cmp_wr_en = 1'b0; cnt_wr_en = 1'b0;
        edges(1);
        cmp_wr_en = 1'b1;
        edges(1);
        cmp_wr_en = 1'b0;
        chk("R9 count", cnt_value, 32'h901);
        chk("R9 clear wins", {31'b0, cmp_hit}, 32'h0);
        edges(4);
        chk("R9 stays clear", {31'b0, cmp_hit}, 32'h0);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule